// File: doc/BRIEF.md
# Bit-Serial Set-Bit Counter

This block counts the set bits of a data word, one bit per clock. A requester flips a start toggle. The block sees that the toggle differs from the copy it sampled on the previous clock, and it captures the data word on that same edge. From then on it tests its working copy of the word. If the copy is zero, the block stops. Otherwise it adds the lowest bit to an accumulator and shifts the copy right by one place. Because the loop stops as soon as no set bits remain, the run time depends on the position of the highest set bit, not on the word width.

On completion the block writes the total to its count output and inverts its done toggle. A requester that keeps the last done value it saw can tell that a new result is ready. The count output holds its value until the next run completes. Start flips that arrive while a run is in progress are dropped: they are not queued.

Top module: `popc_serial`

## Requirements
- R1: After a synchronous reset the block is idle, `count_out` is 0 and `done_tgl` is 0.
- R2: A start event is a clock edge at which `start_tgl` differs from its value at the previous edge. On that edge, when idle, `data_in` is captured, and later changes of `data_in` do not affect the result.
- R3: While idle with no start event, `count_out` and `done_tgl` do not change.
- R4: The published count equals the number of 1 bits in the captured word.
- R5: Let the capturing edge be edge 0. For a zero word, `done_tgl` inverts on edge 1. Otherwise it inverts on edge h+2, where h is the index of the highest set bit.
- R6: An all-ones word gives a count of WIDTH, with `done_tgl` inverting on edge WIDTH+1.
- R7: `count_out` changes only on an edge where `done_tgl` inverts.
- R8: Start events detected while a run is in progress, including on its completing edge, are ignored. The result reflects the first word, and no further done inversion follows.
- R9: Each completed run inverts `done_tgl` exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | WIDTH | Word to be counted, sampled on the start edge |
| start_tgl | input | 1 | Start toggle; each inversion requests one run |
| count_out | output | $clog2(WIDTH+1) | Number of set bits from the last completed run |
| done_tgl | output | 1 | Done toggle; inverts once per completed run |

## Verification
The assertions assume that `start_tgl` and `data_in` are synchronous to the clock and that `start_tgl` inverts at most once between two edges. Under that assumption, every start event corresponds to one real request. The stimulus changes inputs only on the falling clock edge and flips `start_tgl` at most once per cycle. It also changes `data_in` just after capture and issues extra flips during a run, so that the ignore rules are exercised while staying within those input assumptions.

// File: rtl/popc_pkg.sv
package popc_pkg;
  typedef enum logic [0:0] {
    PC_IDLE = 1'b0,
    PC_SCAN = 1'b1
  } pc_state_e;
endpackage

// File: rtl/popc_tgl_detect.sv
module popc_tgl_detect (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic evt
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= tgl_in;
  end

  assign evt = (tgl_in != seen_q);
endmodule

// File: rtl/popc_fsm.sv
module popc_fsm
  import popc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_evt,
  input  logic work_zero,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);
  pc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    finish  = 1'b0;
    unique case (state_q)
      PC_IDLE: begin
        if (start_evt) begin
          load    = 1'b1;
          state_d = PC_SCAN;
        end
      end
      PC_SCAN: begin
        if (work_zero) begin
          finish  = 1'b1;
          state_d = PC_IDLE;
        end else begin
          step = 1'b1;
        end
      end
      default: state_d = PC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PC_IDLE;
    else     state_q <= state_d;
  end

  assign busy = (state_q == PC_SCAN);
endmodule

// File: rtl/popc_scan_dp.sv
module popc_scan_dp #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] work,
  output logic [CNT_W-1:0] acc,
  output logic             work_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      work <= '0;
      acc  <= '0;
    end else if (load) begin
      work <= data;
      acc  <= '0;
    end else if (step) begin
      work <= work >> 1;
      acc  <= acc + CNT_W'(work[0]);
    end
  end

  assign work_zero = (work == '0);
endmodule

// File: rtl/popc_serial.sv
module popc_serial #(
  parameter int WIDTH = 16,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_in,
  input  logic             start_tgl,
  output logic [CNT_W-1:0] count_out,
  output logic             done_tgl
);
  logic             start_evt;
  logic             load, step, finish, busy, work_zero;
  logic [WIDTH-1:0] work_q;
  logic [CNT_W-1:0] acc_q;

  popc_tgl_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .tgl_in (start_tgl),
    .evt    (start_evt)
  );

  popc_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .work_zero (work_zero),
    .load      (load),
    .step      (step),
    .finish    (finish),
    .busy      (busy)
  );

  popc_scan_dp #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .data      (data_in),
    .work      (work_q),
    .acc       (acc_q),
    .work_zero (work_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count_out <= '0;
      done_tgl  <= 1'b0;
    end else if (finish) begin
      count_out <= acc_q;
      done_tgl  <= ~done_tgl;
    end
  end
endmodule

// File: rtl/popc_serial_chk.sv
module popc_serial_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_out,
  input logic             done_tgl,
  input logic             busy,
  input logic [WIDTH-1:0] work_q,
  input logic [CNT_W-1:0] acc_q
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (count_out == '0 && done_tgl == 1'b0 && !busy)); // R1

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    $stable(done_tgl) |-> $stable(count_out)); // R7

  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    !$stable(done_tgl) |-> $past(busy)); // R9

  AST_ONES_CONSERVED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      (int'(acc_q) + $countones(work_q) ==
       int'($past(acc_q)) + $countones($past(work_q)))); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(count_out) <= WIDTH); // R6
endmodule

bind popc_serial popc_serial_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .count_out (count_out),
  .done_tgl  (done_tgl),
  .busy      (busy),
  .work_q    (work_q),
  .acc_q     (acc_q)
);

// File: tb/tb_popc_serial.sv
module tb_popc_serial;
  localparam int WIDTH = 16;
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [WIDTH-1:0] data_in = '0;
  logic             start_tgl = 1'b0;
  logic [CNT_W-1:0] count_out;
  logic             done_tgl;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  popc_serial #(.WIDTH(WIDTH)) dut (
    .clk       (clk),
    .rst       (rst),
    .data_in   (data_in),
    .start_tgl (start_tgl),
    .count_out (count_out),
    .done_tgl  (done_tgl)
  );

  function automatic int ones_of(logic [WIDTH-1:0] w);
    int n = 0;
    for (int i = 0; i < WIDTH; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int edges_for(logic [WIDTH-1:0] w);
    int h = -1;
    for (int i = 0; i < WIDTH; i++) if (w[i]) h = i;
    return (h < 0) ? 1 : h + 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Flip start and capture w; optionally flip start again after extra cycles.
  // Returns the number of edges after capture until done inverts.
  task automatic run_word(logic [WIDTH-1:0] w, int late_flip, logic [WIDTH-1:0] late_data,
                          output int edges, output bit timed_out);
    logic prev_done;
    int n;
    prev_done = done_tgl;
    @(negedge clk);
    data_in   = w;
    start_tgl = ~start_tgl;
    @(posedge clk);           // capture edge 0
    @(negedge clk);
    data_in = ~w;             // R2: later changes must not matter
    n = 0;
    timed_out = 1'b0;
    while (done_tgl == prev_done) begin
      if (late_flip > 0 && n == late_flip - 1) begin
        data_in   = late_data;
        start_tgl = ~start_tgl;
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n > 4 * WIDTH) begin
        timed_out = 1'b1;
        break;
      end
    end
    edges = n;
  endtask

  task automatic do_case(logic [WIDTH-1:0] w, string tag);
    int e;
    bit to;
    logic d0;
    d0 = done_tgl;
    run_word(w, 0, '0, e, to);
    check(!to, {tag, " R9 done inverted"}, int'(to), 0);
    check(done_tgl == ~d0, {tag, " R9 single inversion"}, int'(done_tgl), int'(~d0));
    check(int'(count_out) == ones_of(w), {tag, " R4 count"}, int'(count_out), ones_of(w));
    check(e == edges_for(w), {tag, " R5 latency"}, e, edges_for(w));
  endtask

  task automatic idle_hold(int cycles);
    logic [CNT_W-1:0] c0;
    logic d0;
    c0 = count_out;
    d0 = done_tgl;
    data_in = ~data_in;
    repeat (cycles) @(negedge clk);
    check(count_out == c0, "R3 R7 idle count hold", int'(count_out), int'(c0));
    check(done_tgl == d0, "R3 idle done hold", int'(done_tgl), int'(d0));
  endtask

  initial begin
    int e;
    bit to;
    logic d0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(count_out == '0, "R1 count after reset", int'(count_out), 0);
    check(done_tgl == 1'b0, "R1 done after reset", int'(done_tgl), 0);
    idle_hold(5);

    do_case('0, "zero");                         // R5 zero word
    do_case('1, "R6 all-ones");
    check(int'(count_out) == WIDTH, "R6 all-ones count", int'(count_out), WIDTH);
    do_case(16'h0001, "lsb");
    do_case(16'h8000, "msb");
    do_case(16'hAAAA, "alt");
    idle_hold(4);

    // R8: start flips during a run are ignored, not queued
    d0 = done_tgl;
    run_word(16'h8001, 3, 16'h0003, e, to);
    check(int'(count_out) == 2, "R8 first word kept", int'(count_out), 2);
    check(e == edges_for(16'h8001), "R8 latency not restarted", e, edges_for(16'h8001));
    repeat (WIDTH + 4) @(negedge clk);
    check(done_tgl == ~d0, "R8 no queued run", int'(done_tgl), int'(~d0));

    // R8: flip landing on the completing edge is ignored
    d0 = done_tgl;
    run_word(16'h0004, 4, 16'h00FF, e, to);
    repeat (WIDTH + 4) @(negedge clk);
    check(done_tgl == ~d0, "R8 flip on finish edge ignored", int'(done_tgl), int'(~d0));
    check(int'(count_out) == 1, "R8 count kept", int'(count_out), 1);

    for (int k = 0; k < 60; k++) begin
      logic [WIDTH-1:0] w;
      w = WIDTH'($urandom);
      if (k % 3 == 1) w = w & WIDTH'($urandom);
      if (k % 5 == 2) w = w >> ($urandom % WIDTH);
      do_case(w, "random");
      if (k % 7 == 0) idle_hold(2);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule